// File: doc/BRIEF.md
# Idle-Driven Power Management Sequencer

This block sits on the system side of a processor and escalates power saving when the processor bus goes quiet. It watches the address-valid strobe and the cycle-definition lines. Any bus cycle, and any change on the cycle-definition lines, counts as activity. A down-counter, clocked by a prescaled tick, measures how long the bus stays idle.

When the first idle timeout runs out, the block sends a one-cycle system-management interrupt request so that software can power down I/O devices. If the bus then stays idle for a second, separately programmed period, the block raises the request again. Software answers with a power-down decision written to a control register. The block then asserts stop-clock to the processor. Once the processor acknowledges with stop-grant, the block can also gate the processor clock, if the control register enables that.

Any later bus activity, or a wake input, reopens the clock first. Stop-clock is released one cycle after that, and monitoring starts again from the first stage.

Top module: `idle_pm_seq`

## Requirements
- R1: Activity is a cycle in which `bus_addr_valid` is high, or in which `bus_cyc_def` differs from its value in the previous cycle. Each activity cycle reloads both the tick prescaler and the idle counter.
- R2: In the first stage, if the clock edge at cycle E samples the last activity, `smi_req` is high in cycle E + LIM1*PRESCALE + 1. At the same edge, `smi_cause` bit 0 is set. LIM1 is the value written at register address 0, and must be at least 1.
- R3: If the bus stays idle after the first request, a second request follows LIM2*PRESCALE + 1 cycles later and sets `smi_cause` bit 1. LIM2 is written at register address 1 and must be at least 1.
- R4: `smi_req` is never high for two cycles in a row.
- R5: Activity during the second stage returns the block to the first stage. The next request then sets only bit 0.
- R6: A write to address 3 clears each `smi_cause` bit whose data bit is 1. Bits written as 0 are left unchanged.
- R7: A write to address 2 with data bit 1 set is a power-down decision. It raises `stop_clk` in the next cycle only if the second request has already been issued and no activity has followed it. In every other state the decision bit is ignored.
- R8: Data bit 0 of an address-2 write enables clock gating. `cpu_clk_en` falls only in the cycle after `stop_grant_ack` is sampled high while `stop_clk` is asserted and gating is enabled. With gating disabled, `cpu_clk_en` stays high.
- R9: While `stop_clk` is asserted, activity or `wake_in` sets `cpu_clk_en` high in the next cycle. `stop_clk` falls one cycle after that, and the block returns to the first stage.
- R10: Activity after the second request, before any decision is written, returns the block to the first stage and leaves `stop_clk` low.
- R11: After reset, `smi_req` = 0, `stop_clk` = 0, `cpu_clk_en` = 1 and `smi_cause` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr_valid | input | 1 | Address-valid strobe of the processor bus |
| bus_cyc_def | input | CYC_W | Cycle-definition lines of the processor bus |
| wake_in | input | 1 | External wake request |
| stop_grant_ack | input | 1 | Stop-grant acknowledge from the processor |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 sets LIM1, 1 sets LIM2, 2 is control, 3 clears cause bits |
| reg_wdata | input | TMR_W | Register write data |
| smi_req | output | 1 | One-cycle system-management interrupt request |
| stop_clk | output | 1 | Stop-clock request to the processor |
| cpu_clk_en | output | 1 | Enable for the processor clock gate |
| smi_cause | output | 2 | Pending cause bits: bit 0 marks the first stage, bit 1 the second |

## Verification
The bench measures the delay from the last activity cycle to each request. This catches a design that is off by one tick or one cycle, or that fails to reload the prescaler when activity arrives. It sends activity during the second stage and after the second request. A design that kept escalating would then set cause bit 1, or raise stop-clock.

The bench writes the power-down decision while the block is still monitoring. A design that took the decision too early would stop the processor without the software handshake. Finally, it follows the gate through acknowledge and wake, in both gated and ungated modes. A design that released stop-clock while the clock was still gated, or that closed the gate before the acknowledge, would show the wrong output in the cycle being checked.

// File: rtl/pm_pkg.sv
package pm_pkg;
    typedef enum logic [2:0] {
        ST_BOOT,
        ST_WATCH,
        ST_SECOND,
        ST_DECIDE,
        ST_GRANT,
        ST_HALTED,
        ST_RESUME
    } pm_state_e;

    localparam logic [1:0] ADDR_LIM1 = 2'd0;
    localparam logic [1:0] ADDR_LIM2 = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;
    localparam logic [1:0] ADDR_CLR  = 2'd3;

    localparam int CTRL_GATE = 0;
    localparam int CTRL_GO   = 1;
endpackage

// File: rtl/pm_activity.sv
module pm_activity #(
    parameter int CYC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addr_valid,
    input  logic [CYC_W-1:0] cyc_def,
    output logic             act
);
    logic [CYC_W-1:0] cyc_d, cyc_q;

    always_comb begin
        cyc_d = cyc_def;
        act   = addr_valid || (cyc_def != cyc_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc_q <= '0;
        else        cyc_q <= cyc_d;
    end

    // R1: a change seen on the registered copy means activity was flagged
    assert_change_is_activity_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q != $past(cyc_q)) |-> $past(act));
endmodule

// File: rtl/pm_idle_timer.sv
module pm_idle_timer #(
    parameter int PRESCALE = 1000,
    parameter int TMR_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic [TMR_W-1:0] load_val,
    output logic             expired
);
    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [TMR_W-1:0] cnt;
    } tmr_t;

    tmr_t d, q;
    logic tick;

    always_comb begin
        d       = q;
        tick    = (q.pre == PRE_LAST);
        expired = (q.cnt == '0);
        if (reload) begin
            d.pre = '0;
            d.cnt = load_val;
        end else begin
            d.pre = tick ? '0 : q.pre + 1'b1;
            if (tick && q.cnt != '0) d.cnt = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R2: without a reload the count only ever moves down
    assert_count_down_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(reload) |-> (q.cnt <= $past(q.cnt)));
endmodule

// File: rtl/pm_seq.sv
module pm_seq
    import pm_pkg::*;
#(
    parameter int               TMR_W    = 16,
    parameter logic [TMR_W-1:0] DEF_LIM1 = 16'd100,
    parameter logic [TMR_W-1:0] DEF_LIM2 = 16'd100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act,
    input  logic             wake,
    input  logic             grant_ack,
    input  logic             expired,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [TMR_W-1:0] reg_wdata,
    output logic             reload,
    output logic [TMR_W-1:0] load_val,
    output logic             smi,
    output logic             stop,
    output logic             clk_en,
    output logic [1:0]       cause
);
    typedef struct packed {
        pm_state_e        state;
        logic [TMR_W-1:0] lim1;
        logic [TMR_W-1:0] lim2;
        logic             gate_en;
        logic             smi;
        logic             stop;
        logic             clk_en;
        logic [1:0]       cause;
    } seq_t;

    seq_t d, q;
    logic go_wr;

    always_comb begin
        d     = q;
        d.smi = 1'b0;
        go_wr = reg_wr && (reg_addr == ADDR_CTRL) && reg_wdata[CTRL_GO];

        if (reg_wr) begin
            unique case (reg_addr)
                ADDR_LIM1: d.lim1    = reg_wdata;
                ADDR_LIM2: d.lim2    = reg_wdata;
                ADDR_CTRL: d.gate_en = reg_wdata[CTRL_GATE];
                ADDR_CLR:  d.cause   = q.cause & ~reg_wdata[1:0];
            endcase
        end

        unique case (q.state)
            ST_BOOT: d.state = ST_WATCH;
            ST_WATCH: begin
                if (!act && expired) begin
                    d.state    = ST_SECOND;
                    d.smi      = 1'b1;
                    d.cause[0] = 1'b1;
                end
            end
            ST_SECOND: begin
                if (act) begin
                    d.state = ST_WATCH;
                end else if (expired) begin
                    d.state    = ST_DECIDE;
                    d.smi      = 1'b1;
                    d.cause[1] = 1'b1;
                end
            end
            ST_DECIDE: begin
                if (act) begin
                    d.state = ST_WATCH;
                end else if (go_wr) begin
                    d.state = ST_GRANT;
                    d.stop  = 1'b1;
                end
            end
            ST_GRANT: begin
                if (act || wake) begin
                    d.state  = ST_RESUME;
                    d.clk_en = 1'b1;
                end else if (grant_ack) begin
                    d.state  = ST_HALTED;
                    d.clk_en = !q.gate_en;
                end
            end
            ST_HALTED: begin
                if (act || wake) begin
                    d.state  = ST_RESUME;
                    d.clk_en = 1'b1;
                end
            end
            ST_RESUME: begin
                d.state = ST_WATCH;
                d.stop  = 1'b0;
            end
            default: d.state = ST_BOOT;
        endcase

        reload   = act || (d.state != q.state);
        load_val = (d.state == ST_SECOND) ? q.lim2 : q.lim1;
        if (reg_wr && reg_addr == ADDR_LIM2 && d.state == ST_SECOND) load_val = reg_wdata;
        if (reg_wr && reg_addr == ADDR_LIM1 && d.state != ST_SECOND) load_val = reg_wdata;

        smi    = q.smi;
        stop   = q.stop;
        clk_en = q.clk_en;
        cause  = q.cause;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.state   <= ST_BOOT;
            q.lim1    <= DEF_LIM1;
            q.lim2    <= DEF_LIM2;
            q.clk_en  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    // R4: interrupt request lasts one cycle
    assert_smi_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        q.smi |=> !q.smi);

    // R7: stop-clock only rises from the decision state on a decision write
    assert_stop_from_decide_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.stop) |-> ($past(q.state) == ST_DECIDE) && $past(go_wr));

    // R8: a closed gate always comes with stop-clock asserted
    assert_gate_needs_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !q.clk_en |-> q.stop);

    // R8: the gate closes only after an acknowledge with gating enabled
    assert_gate_after_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.clk_en) |-> $past(grant_ack) && $past(q.gate_en));

    // R9: stop-clock is released only with the clock already running
    assert_release_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.stop) |-> q.clk_en && $past(q.clk_en));

    // R9: wake or activity in the halted state reopens the clock next cycle
    assert_wake_opens_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_HALTED) && (act || wake) |=> q.clk_en);
endmodule

// File: rtl/idle_pm_seq.sv
module idle_pm_seq #(
    parameter int               PRESCALE = 1000,
    parameter int               TMR_W    = 16,
    parameter int               CYC_W    = 3,
    parameter logic [TMR_W-1:0] DEF_LIM1 = TMR_W'(100),
    parameter logic [TMR_W-1:0] DEF_LIM2 = TMR_W'(100)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_addr_valid,
    input  logic [CYC_W-1:0] bus_cyc_def,
    input  logic             wake_in,
    input  logic             stop_grant_ack,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [TMR_W-1:0] reg_wdata,
    output logic             smi_req,
    output logic             stop_clk,
    output logic             cpu_clk_en,
    output logic [1:0]       smi_cause
);
    logic             act;
    logic             reload;
    logic             expired;
    logic [TMR_W-1:0] load_val;

    pm_activity #(.CYC_W(CYC_W)) u_act (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_valid (bus_addr_valid),
        .cyc_def    (bus_cyc_def),
        .act        (act)
    );

    pm_idle_timer #(.PRESCALE(PRESCALE), .TMR_W(TMR_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload   (reload),
        .load_val (load_val),
        .expired  (expired)
    );

    pm_seq #(.TMR_W(TMR_W), .DEF_LIM1(DEF_LIM1), .DEF_LIM2(DEF_LIM2)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (act),
        .wake      (wake_in),
        .grant_ack (stop_grant_ack),
        .expired   (expired),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reload    (reload),
        .load_val  (load_val),
        .smi       (smi_req),
        .stop      (stop_clk),
        .clk_en    (cpu_clk_en),
        .cause     (smi_cause)
    );
endmodule

// File: tb/idle_pm_seq_test.sv
module idle_pm_seq_test;
    localparam int P  = 4;
    localparam int TW = 8;
    localparam int CW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_addr_valid = 1'b0;
    logic [CW-1:0] bus_cyc_def = '0;
    logic          wake_in = 1'b0;
    logic          stop_grant_ack = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic [TW-1:0] reg_wdata = '0;
    logic          smi_req, stop_clk, cpu_clk_en;
    logic [1:0]    smi_cause;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int wd = 0;

    idle_pm_seq #(.PRESCALE(P), .TMR_W(TW), .CYC_W(CW),
                  .DEF_LIM1(8'd20), .DEF_LIM2(8'd20)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr_valid(bus_addr_valid),
        .bus_cyc_def(bus_cyc_def), .wake_in(wake_in), .stop_grant_ack(stop_grant_ack),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .smi_req(smi_req), .stop_clk(stop_clk), .cpu_clk_en(cpu_clk_en),
        .smi_cause(smi_cause)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        wd  <= wd + 1;
        if (wd > 20000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    typedef struct packed {
        logic          kind;
        logic [TW-1:0] l1;
        logic [TW-1:0] l2;
    } vec_t;

    // kind 0: address strobe, kind 1: cycle-definition change
    localparam vec_t VECS [5] = '{
        {1'b0, 8'd1, 8'd1},
        {1'b1, 8'd2, 8'd3},
        {1'b0, 8'd5, 8'd1},
        {1'b1, 8'd3, 8'd7},
        {1'b0, 8'd4, 8'd2}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [TW-1:0] v);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse_act(input logic kind, output int e);
        if (kind) bus_cyc_def = bus_cyc_def + 1'b1;
        else      bus_addr_valid = 1'b1;
        @(negedge clk);
        e = cyc;
        bus_addr_valid = 1'b0;
    endtask

    task automatic wait_smi(output int e);
        e = -1;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (smi_req) begin
                e = cyc;
                break;
            end
        end
    endtask

    task automatic reach_decide();
        int e, s;
        pulse_act(1'b0, e);
        wait_smi(s);
        wait_smi(s);
        wr(2'd3, 8'd3);
    endtask

    initial begin
        int e, s1, s2, exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        check(smi_req == 1'b0, "R11 smi", smi_req, 0);
        check(stop_clk == 1'b0, "R11 stop", stop_clk, 0);
        check(cpu_clk_en == 1'b1, "R11 clk_en", cpu_clk_en, 1);
        check(smi_cause == 2'b00, "R11 cause", smi_cause, 0);

        // Table: R1 R2 R3 R4 R6
        for (int v = 0; v < 5; v++) begin
            wr(2'd0, VECS[v].l1);
            wr(2'd1, VECS[v].l2);
            pulse_act(VECS[v].kind, e);
            wait_smi(s1);
            exp = e + int'(VECS[v].l1) * P + 1;
            check(s1 == exp, "R1 R2 first request cycle", s1, exp);
            check(smi_cause == 2'b01, "R2 cause bit0", smi_cause, 1);
            @(negedge clk);
            check(smi_req == 1'b0, "R4 single pulse", smi_req, 0);
            wr(2'd3, 8'd2);
            check(smi_cause == 2'b01, "R6 clear other bit", smi_cause, 1);
            wait_smi(s2);
            exp = s1 + int'(VECS[v].l2) * P + 1;
            check(s2 == exp, "R3 second request cycle", s2, exp);
            check(smi_cause == 2'b11, "R3 cause bit1", smi_cause, 3);
            wr(2'd3, 8'd3);
            check(smi_cause == 2'b00, "R6 clear both", smi_cause, 0);
        end

        // R5 activity in the second stage
        wr(2'd0, 8'd2);
        wr(2'd1, 8'd6);
        pulse_act(1'b0, e);
        wait_smi(s1);
        wr(2'd3, 8'd1);
        repeat (2) @(negedge clk);
        pulse_act(1'b1, e);
        wait_smi(s1);
        check(s1 == e + 2 * P + 1, "R5 back to first stage timing", s1, e + 2 * P + 1);
        check(smi_cause == 2'b01, "R5 first-stage cause", smi_cause, 1);
        wr(2'd3, 8'd3);

        // R7 decision ignored while monitoring
        wr(2'd0, 8'd50);
        pulse_act(1'b0, e);
        wr(2'd2, 8'd2);
        repeat (3) @(negedge clk);
        check(stop_clk == 1'b0, "R7 decision ignored", stop_clk, 0);
        check(cpu_clk_en == 1'b1, "R7 clock kept", cpu_clk_en, 1);

        // R10 activity in the decision state
        wr(2'd0, 8'd2);
        wr(2'd1, 8'd2);
        reach_decide();
        pulse_act(1'b1, e);
        check(stop_clk == 1'b0, "R10 no stop", stop_clk, 0);
        wait_smi(s1);
        check(s1 == e + 2 * P + 1, "R10 restart timing", s1, e + 2 * P + 1);
        check(smi_cause == 2'b01, "R10 first-stage cause", smi_cause, 1);
        wr(2'd3, 8'd3);

        // R7 R8 R9 gated stop
        reach_decide();
        wr(2'd2, 8'd3);
        check(stop_clk == 1'b1, "R7 stop raised", stop_clk, 1);
        check(cpu_clk_en == 1'b1, "R8 gate open before ack", cpu_clk_en, 1);
        repeat (2) @(negedge clk);
        check(cpu_clk_en == 1'b1, "R8 no ack no gate", cpu_clk_en, 1);
        stop_grant_ack = 1'b1;
        @(negedge clk);
        stop_grant_ack = 1'b0;
        check(cpu_clk_en == 1'b0, "R8 gate closed", cpu_clk_en, 0);
        repeat (3) @(negedge clk);
        check(stop_clk == 1'b1 && cpu_clk_en == 1'b0, "R8 held stopped", cpu_clk_en, 0);
        wake_in = 1'b1;
        @(negedge clk);
        wake_in = 1'b0;
        check(cpu_clk_en == 1'b1, "R9 clock reopened", cpu_clk_en, 1);
        check(stop_clk == 1'b1, "R9 stop still held", stop_clk, 1);
        @(negedge clk);
        check(stop_clk == 1'b0, "R9 stop released", stop_clk, 0);
        wait_smi(s1);
        check(smi_cause == 2'b01, "R9 back to monitoring", smi_cause, 1);
        wr(2'd3, 8'd3);

        // R8 R9 ungated stop released by bus activity
        reach_decide();
        wr(2'd2, 8'd2);
        stop_grant_ack = 1'b1;
        @(negedge clk);
        stop_grant_ack = 1'b0;
        check(cpu_clk_en == 1'b1, "R8 ungated clock stays", cpu_clk_en, 1);
        check(stop_clk == 1'b1, "R8 ungated stop held", stop_clk, 1);
        pulse_act(1'b0, e);
        check(stop_clk == 1'b1, "R9 stop one more cycle", stop_clk, 1);
        @(negedge clk);
        check(stop_clk == 1'b0, "R9 activity releases", stop_clk, 0);

        // R9 activity before the acknowledge
        reach_decide();
        wr(2'd2, 8'd3);
        pulse_act(1'b1, e);
        check(cpu_clk_en == 1'b1, "R9 early release clock", cpu_clk_en, 1);
        @(negedge clk);
        check(stop_clk == 1'b0, "R9 early release stop", stop_clk, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule